// File: doc/BRIEF.md
# Interval Timer Channel

One channel of a programmable up-counting interval timer. A 32-bit count advances by one on every tick enable (nominally 1 MHz) while the channel is running. When an increment carries the count past all ones, the channel records the event in a done flag, or in an error flag if done was still pending. It may halt itself, it reloads the count from a separate reload register, and it can raise an interrupt request whose vector is presented on acknowledge. Software can also copy the reload value into the count directly, or advance the count by a single step while the channel is halted.

The channel is controlled through a small register bus with one address for reads and writes. The run bit is held as a two-state machine, `ST_HALT` and `ST_COUNT`. Transitions: `HALT→COUNT` on a control write with run set. `COUNT→HALT` on a control write with run clear, or on an overflow while stop-on-overflow is set. `COUNT→COUNT` on an overflow without stop, and the count is reloaded. `HALT→HALT` otherwise. A power-up reset clears everything. A soft clear resets the control, count, reload and interrupt state but keeps the vector.

Top module: `tmr_channel`

## Requirements
- R1: After power-up reset (rst_n low) all four registers read 0 and irq is 0.
- R2: A cycle with soft_clr high clears control, count, reload and irq and ignores any write, but the vector register keeps its value.
- R3: While run is 1, each tick adds one to the count. Without a tick, or with run 0, the count holds. A bus write to the count address has no effect.
- R4: A tick while the count is 0xFFFFFFFF is an overflow. It sets done (control bit 7) if done was 0, otherwise it sets error (control bit 31).
- R5: On overflow with stop (control bit 2) set, run (bit 0) is cleared and the count becomes 0. If run stays set, the count is loaded from the reload register.
- R6: irq rises after an overflow when interrupt enable (bit 6) is set. It falls whenever done and enable are not both 1. Setting enable while done is already 1 does not raise it.
- R7: A control write with transfer (bit 4) set copies the reload register into the count.
- R8: A control write with step (bit 5) set and run clear adds one to the count, after any transfer in the same write. If the result is 0, the count is loaded from the reload register instead. With run set in the same write, no step occurs.
- R9: Writing 1 to error or done clears that flag, and writing 0 leaves it. Interrupt enable, stop and run take the written value. Step and transfer always read as 0.
- R10: Only write-data bits 9:2 are stored in the vector register, which reads back in the same positions. While int_ack is high, ack_vec carries the vector in bits 9:2; otherwise it is 0.
- R11: A tick in the same cycle as a control write is applied to the state that the write produces.
- R12: Register addresses: 0 control, 1 count (read-only), 2 reload (read/write, 32 bits), 3 vector. rd_data shows the register at addr combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| soft_clr | input | 1 | Synchronous clear of all state except the vector |
| addr | input | 2 | Register address for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the addressed register |
| tick | input | 1 | Count enable pulse |
| irq | output | 1 | Interrupt request |
| int_ack | input | 1 | Interrupt acknowledge |
| ack_vec | output | 10 | Vector presented during acknowledge |

## Verification
The assertions take soft_clr and power-up reset as the only sources of sudden state loss. Their overflow and advance properties apply only in cycles with no control write, because a write may legitimately rewrite run, stop or the count. The properties rely on tick being a single-cycle enable that is never held across a write in a way the model cannot follow. The stimulus keeps every input stable around the rising edge. The scripted phase reaches each overflow by loading the reload register with values just below all ones. The pseudo-random phase keeps the reload value near the wrap point so that done, error, stop and reload interact often.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DATA_W = 32;

    // control register bit positions (software-visible layout)
    localparam int B_ERR  = 31;
    localparam int B_DONE = 7;
    localparam int B_IE   = 6;
    localparam int B_STEP = 5;
    localparam int B_XFER = 4;
    localparam int B_STOP = 2;
    localparam int B_RUN  = 0;

    typedef enum logic [1:0] {
        RA_CTRL   = 2'd0,
        RA_COUNT  = 2'd1,
        RA_RELOAD = 2'd2,
        RA_VECTOR = 2'd3
    } reg_addr_e;

    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_e;

    typedef struct packed {
        logic err;
        logic done;
        logic ie;
        logic stop;
    } ctl_flags_t;

    typedef struct packed {
        logic err;
        logic done;
        logic ie;
        logic step;
        logic xfer;
        logic stop;
        logic run;
    } ctl_wdata_t;
endpackage

// File: rtl/tmr_run_fsm.sv
module tmr_run_fsm
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_clr,
    input  logic       ctl_wr,
    input  ctl_wdata_t wd,
    input  logic       ovf,
    output logic       run_w,
    output logic       run_n,
    output logic       xfer_cmd,
    output logic       step_cmd,
    output ctl_flags_t flags_q,
    output logic       run_q,
    output logic       irq_q
);
    run_state_e state_q, state_d;
    ctl_flags_t flags_w, flags_d;
    logic       irq_d;

    // control write first, overflow effects on top of it
    always_comb begin
        flags_w = flags_q;
        run_w   = (state_q == ST_COUNT);
        if (ctl_wr) begin
            flags_w.err  = flags_q.err  & ~wd.err;
            flags_w.done = flags_q.done & ~wd.done;
            flags_w.ie   = wd.ie;
            flags_w.stop = wd.stop;
            run_w        = wd.run;
        end
        flags_d      = flags_w;
        flags_d.err  = flags_w.err | (ovf & flags_w.done);
        flags_d.done = flags_w.done | ovf;
        run_n        = run_w & ~(ovf & flags_w.stop);
        irq_d        = (irq_q | (ovf & flags_w.ie)) & flags_d.done & flags_w.ie;
    end

    always_comb begin
        unique case (state_q)
            ST_HALT:  state_d = run_n ? ST_COUNT : ST_HALT;
            ST_COUNT: state_d = run_n ? ST_COUNT : ST_HALT;
        endcase
    end

    assign xfer_cmd = ctl_wr & wd.xfer;
    assign step_cmd = ctl_wr & wd.step & ~wd.run;
    assign run_q    = (state_q == ST_COUNT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state_q <= ST_HALT;
        else if (soft_clr) state_q <= ST_HALT;
        else               state_q <= state_d;
    end

    // flag and request registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            irq_q   <= 1'b0;
        end else if (soft_clr) begin
            flags_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            flags_q <= flags_d;
            irq_q   <= irq_d;
        end
    end
endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             xfer_cmd,
    input  logic             step_cmd,
    input  logic             tick,
    input  logic             run_w,
    input  logic             run_n,
    input  logic             rld_wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] reload_q,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] TOP  = '1;

    logic [CNT_W-1:0] moved, stepped, after_wr, count_d;
    logic             adv;

    always_comb begin
        moved    = xfer_cmd ? reload_q : count_q;
        stepped  = moved + ONE;
        after_wr = moved;
        if (step_cmd) after_wr = (stepped == '0) ? reload_q : stepped;
        adv      = tick & run_w;
        ovf      = adv & (after_wr == TOP);
        if (ovf)      count_d = run_n ? reload_q : '0;
        else if (adv) count_d = after_wr + ONE;
        else          count_d = after_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            reload_q <= '0;
        end else if (soft_clr) begin
            count_q  <= '0;
            reload_q <= '0;
        end else begin
            count_q <= count_d;
            if (rld_wr) reload_q <= wdata;
        end
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int VEC_HI = 9,
    parameter int VEC_LO = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tick,
    output logic              irq,
    input  logic              int_ack,
    output logic [VEC_HI:0]   ack_vec
);
    localparam int VEC_W = VEC_HI - VEC_LO + 1;

    logic             ctl_wr, rld_wr, vec_wr;
    ctl_wdata_t       wd;
    logic             run_w, run_n, xfer_cmd, step_cmd, run_q, ovf;
    ctl_flags_t       flg_q;
    logic [CNT_W-1:0] count_q, reload_q;
    logic [VEC_W-1:0] vec_q;

    assign ctl_wr = wr_en & (reg_addr_e'(addr) == RA_CTRL);
    assign rld_wr = wr_en & (reg_addr_e'(addr) == RA_RELOAD);
    assign vec_wr = wr_en & (reg_addr_e'(addr) == RA_VECTOR);

    assign wd = '{err:  wr_data[B_ERR],  done: wr_data[B_DONE], ie: wr_data[B_IE],
                  step: wr_data[B_STEP], xfer: wr_data[B_XFER],
                  stop: wr_data[B_STOP], run:  wr_data[B_RUN]};

    tmr_run_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .ctl_wr   (ctl_wr),
        .wd       (wd),
        .ovf      (ovf),
        .run_w    (run_w),
        .run_n    (run_n),
        .xfer_cmd (xfer_cmd),
        .step_cmd (step_cmd),
        .flags_q  (flg_q),
        .run_q    (run_q),
        .irq_q    (irq)
    );

    tmr_count_unit #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .xfer_cmd (xfer_cmd),
        .step_cmd (step_cmd),
        .tick     (tick),
        .run_w    (run_w),
        .run_n    (run_n),
        .rld_wr   (rld_wr),
        .wdata    (wr_data[CNT_W-1:0]),
        .count_q  (count_q),
        .reload_q (reload_q),
        .ovf      (ovf)
    );

    // vector survives soft clear; only power-up clears it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   vec_q <= '0;
        else if (vec_wr && !soft_clr) vec_q <= wr_data[VEC_HI:VEC_LO];
    end

    always_comb begin
        rd_data = '0;
        unique case (reg_addr_e'(addr))
            RA_CTRL: begin
                rd_data[B_ERR]  = flg_q.err;
                rd_data[B_DONE] = flg_q.done;
                rd_data[B_IE]   = flg_q.ie;
                rd_data[B_STOP] = flg_q.stop;
                rd_data[B_RUN]  = run_q;
            end
            RA_COUNT:  rd_data = DATA_W'(count_q);
            RA_RELOAD: rd_data = DATA_W'(reload_q);
            RA_VECTOR: rd_data[VEC_HI:VEC_LO] = vec_q;
        endcase
    end

    assign ack_vec = int_ack ? {vec_q, {VEC_LO{1'b0}}} : '0;
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             soft_clr,
    input logic             ctl_wr,
    input logic             tick,
    input logic             irq,
    input ctl_flags_t       flags,
    input logic             run,
    input logic [CNT_W-1:0] count,
    input logic [VEC_W-1:0] vec
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic quiet, wrap_tick;
    assign quiet     = !soft_clr && !ctl_wr;
    assign wrap_tick = quiet && tick && run && (count == '1);

    AST_IRQ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags.done && flags.ie)); // R6

    AST_OVF_MARKS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_tick |=> flags.done); // R4

    AST_REPEAT_OVF_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_tick && flags.done) |=> flags.err); // R4

    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_tick && flags.stop) |=> (!run && count == '0)); // R5

    AST_TICK_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && tick && run && count != '1) |=> (count == $past(count) + ONE)); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && !run) |=> $stable(count)); // R3

    AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (!run && count == '0 && !irq)); // R2

    AST_VEC_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> $stable(vec)); // R2
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (soft_clr),
    .ctl_wr   (ctl_wr),
    .tick     (tick),
    .irq      (irq),
    .flags    (flg_q),
    .run      (run_q),
    .count    (count_q),
    .vec      (vec_q)
);

// File: tb/tmr_channel_bench.sv
module tmr_channel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_clr = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = 32'd0;
    logic [31:0] rd_data;
    logic        tick = 1'b0;
    logic        irq;
    logic        int_ack = 1'b0;
    logic [9:0]  ack_vec;

    int n_chk = 0;
    int n_fail = 0;
    string cur_req = "R1";

    // reference model state
    bit        m_err, m_done, m_ie, m_stop, m_run, m_irq;
    bit [31:0] m_cnt, m_nxt;
    bit [7:0]  m_vec;

    always #10 clk = ~clk;

    tmr_channel u_tmr_channel (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .tick(tick),
        .irq(irq), .int_ack(int_ack), .ack_vec(ack_vec)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit [31:0] m_read(input bit [1:0] a);
        case (a)
            2'd0: return {m_err, 23'd0, m_done, m_ie, 3'b000, m_stop, 1'b0, m_run};
            2'd1: return m_cnt;
            2'd2: return m_nxt;
            default: return {22'd0, m_vec, 2'b00};
        endcase
    endfunction

    task automatic model_step();
        if (!rst_n) begin
            {m_err, m_done, m_ie, m_stop, m_run, m_irq} = '0;
            m_cnt = 0; m_nxt = 0; m_vec = 0;
        end else if (soft_clr) begin
            {m_err, m_done, m_ie, m_stop, m_run, m_irq} = '0;
            m_cnt = 0; m_nxt = 0;
        end else begin
            if (wr_en) begin
                if (addr == 2'd0) begin
                    if (wr_data[31]) m_err = 0;
                    if (wr_data[7]) m_done = 0;
                    m_ie = wr_data[6]; m_stop = wr_data[2]; m_run = wr_data[0];
                    if (wr_data[4]) m_cnt = m_nxt;
                    if (wr_data[5] && !wr_data[0]) begin
                        m_cnt = m_cnt + 1;
                        if (m_cnt == 0) m_cnt = m_nxt;
                    end
                end else if (addr == 2'd2) m_nxt = wr_data;
                else if (addr == 2'd3) m_vec = wr_data[9:2];
            end
            if (tick && m_run) begin
                if (m_cnt == 32'hFFFF_FFFF) begin
                    if (m_done) m_err = 1; else m_done = 1;
                    if (m_stop) m_run = 0;
                    m_cnt = m_run ? m_nxt : 0;
                    if (m_ie) m_irq = 1;
                end else m_cnt = m_cnt + 1;
            end
            if (!(m_done && m_ie)) m_irq = 0;
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk({cur_req, " rd_data"}, rd_data, m_read(addr));
        chk({cur_req, " irq"}, {31'd0, irq}, {31'd0, m_irq});
        chk({cur_req, " ack_vec"}, {22'd0, ack_vec}, int_ack ? {22'd0, m_vec, 2'b00} : 32'd0);
    endtask

    task automatic wr(input bit [1:0] a, input bit [31:0] d, input bit tk = 0);
        addr = a; wr_en = 1; wr_data = d; tick = tk;
        cyc();
        wr_en = 0; tick = 0;
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1; cyc(); tick = 0; cyc();
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic rd_chk(input bit [1:0] a, input bit [31:0] exp, input string tag);
        addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        bit [31:0] s;
        idle(3);
        rst_n = 1;
        idle(1);
        // R1 reset state
        cur_req = "R1";
        for (int a = 0; a < 4; a++) rd_chk(a[1:0], 32'd0, "R1 reset read");
        chk("R1 irq", {31'd0, irq}, 32'd0);

        // R10 vector field
        cur_req = "R10";
        wr(2'd3, 32'hFFFF_FFFF);
        rd_chk(2'd3, 32'h0000_03FC, "R10 vector read");
        int_ack = 1; #1;
        chk("R10 ack_vec", {22'd0, ack_vec}, 32'h3FC);
        int_ack = 0; #1;
        chk("R10 ack_vec idle", {22'd0, ack_vec}, 32'h0);

        // R12 map, R3 count read-only, R7 transfer
        cur_req = "R12";
        wr(2'd2, 32'hFFFF_FFFD);
        rd_chk(2'd2, 32'hFFFF_FFFD, "R12 reload read");
        cur_req = "R3";
        wr(2'd1, 32'h0000_1234);
        rd_chk(2'd1, 32'd0, "R3 count write ignored");
        cur_req = "R7";
        wr(2'd0, 32'h10);
        rd_chk(2'd1, 32'hFFFF_FFFD, "R7 transfer");
        rd_chk(2'd0, 32'h0, "R9 write-only bits read 0");

        // R3 counting
        cur_req = "R3";
        wr(2'd0, 32'h41);
        rd_chk(2'd0, 32'h41, "R9 ctrl readback");
        idle(3);
        rd_chk(2'd1, 32'hFFFF_FFFD, "R3 hold without tick");
        tk(1);
        rd_chk(2'd1, 32'hFFFF_FFFE, "R3 tick advance");
        tk(1);
        rd_chk(2'd1, 32'hFFFF_FFFF, "R3 tick advance");

        // R4/R5/R6 overflow with reload
        cur_req = "R4";
        tk(1);
        rd_chk(2'd1, 32'hFFFF_FFFD, "R5 reload on overflow");
        rd_chk(2'd0, 32'hC1, "R4 done set");
        chk("R6 irq raised", {31'd0, irq}, 32'd1);
        tk(3);
        rd_chk(2'd0, 32'h8000_00C1, "R4 error on repeat");

        // R9 W1C, R6 withdrawal
        cur_req = "R9";
        wr(2'd0, 32'h8000_0041);
        rd_chk(2'd0, 32'hC1, "R9 error cleared only");
        chk("R6 irq kept", {31'd0, irq}, 32'd1);
        cur_req = "R6";
        wr(2'd0, 32'hC1);
        rd_chk(2'd0, 32'h41, "R9 done cleared");
        chk("R6 irq dropped", {31'd0, irq}, 32'd0);

        // R5 stop on overflow
        cur_req = "R5";
        wr(2'd0, 32'h45);
        tk(3);
        rd_chk(2'd1, 32'd0, "R5 stop zeroes count");
        rd_chk(2'd0, 32'hC4, "R5 run cleared");
        chk("R6 irq on stop ovf", {31'd0, irq}, 32'd1);
        tk(1);
        rd_chk(2'd1, 32'd0, "R3 halted ignores tick");
        cur_req = "R6";
        wr(2'd0, 32'h04);
        chk("R6 irq off with ie 0", {31'd0, irq}, 32'd0);
        wr(2'd0, 32'h44);
        chk("R6 ie again no irq", {31'd0, irq}, 32'd0);
        wr(2'd0, 32'h80);
        rd_chk(2'd0, 32'h0, "R9 clear done");

        // R8 single step
        cur_req = "R8";
        wr(2'd2, 32'd5);
        wr(2'd0, 32'h20);
        rd_chk(2'd1, 32'd1, "R8 step");
        wr(2'd0, 32'h21);
        rd_chk(2'd1, 32'd1, "R8 no step when run");
        wr(2'd0, 32'h00);
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd0, 32'h10);
        wr(2'd2, 32'd7);
        wr(2'd0, 32'h20);
        rd_chk(2'd1, 32'd7, "R8 wrap reload");

        // R11 tick with write
        cur_req = "R11";
        wr(2'd0, 32'h01, 1);
        rd_chk(2'd1, 32'd8, "R11 run write then tick");
        wr(2'd0, 32'h00, 1);
        rd_chk(2'd1, 32'd8, "R11 stop write then tick");

        // R2 soft clear
        cur_req = "R2";
        wr(2'd2, 32'd9);
        wr(2'd0, 32'h41);
        tk(1);
        soft_clr = 1; addr = 2'd3; wr_en = 1; wr_data = 32'h0;
        cyc();
        soft_clr = 0; wr_en = 0;
        for (int a = 0; a < 3; a++) rd_chk(a[1:0], 32'd0, "R2 cleared");
        rd_chk(2'd3, 32'h3FC, "R2 vector kept");
        chk("R2 irq", {31'd0, irq}, 32'd0);

        // pseudo-random phase against the model
        cur_req = "R4";
        wr(2'd2, 32'hFFFF_FFF0);
        wr(2'd0, 32'h10);
        s = 32'h1234_5678;
        for (int i = 0; i < 3000; i++) begin
            s ^= s << 13; s ^= s >> 17; s ^= s << 5;
            tick    = s[0] | s[11];
            int_ack = s[12];
            addr    = s[14:13];
            wr_en   = (s[18:15] == 4'd0);
            if (wr_en) begin
                if (s[20:19] == 2'd2) begin
                    addr = 2'd2; wr_data = {28'hFFFF_FFF, s[24:21]};
                end else begin
                    addr = 2'd0;
                    wr_data = '0;
                    wr_data[31] = s[1]; wr_data[7] = s[2]; wr_data[6] = s[3];
                    wr_data[5]  = s[4] & s[9]; wr_data[4] = s[5] & s[10];
                    wr_data[2]  = s[6]; wr_data[0] = s[7] | s[8];
                end
            end
            cyc();
        end
        wr_en = 0; tick = 0; int_ack = 0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule